// File: doc/BRIEF.md
# AUX Reply Timeout Timer

This block times the wait for a reply on a DisplayPort-style AUX channel. Software or a sequencer gives a reply timeout in microseconds with a load strobe. The block turns that value into two fields: a coarse 7-bit length and a 2-bit granularity code. The code selects a unit of 8, 16, 32 or 64 microseconds. The timer period is the length times the unit, so a long timeout costs only a few bits of storage, at the price of some rounding.

When the request has been sent, a start pulse arms the timer. The timer then counts 1 MHz tick strobes. If a reply-detected strobe arrives first, the timer stops quietly. If the full period passes, it raises a one-cycle timeout pulse and goes idle. The physical channel, the decoding of reply bits and the retry policy belong to the surrounding logic.

The controller has three states. `ST_IDLE` waits for start. `ST_RUN` counts units and is the only state in which busy is high. `ST_FIRE` lasts one cycle and drives the timeout pulse. The transitions are:

- idle-to-run: start with a non-zero length.
- idle-to-fire: start with a zero length.
- run-to-idle: a reply strobe.
- run-to-fire: the tick that completes the last unit.
- fire-to-idle: always, in the next cycle.

Top module: `aux_reply_timer`

## Requirements
- R1: The granularity code (`cfg_mul_o`) is 0 for a timeout of at most 1016 µs, 1 for 1017..2032 µs, 2 for 2033..4064 µs and 3 above 4064 µs. Code n means a unit of 8·2^n µs.
- R2: The length (`cfg_len_o`) is the timeout divided by the unit, rounded up when there is any remainder. A timeout of 0 gives length 0.
- R3: The length saturates at 127. Any timeout whose rounded-up quotient exceeds 127 yields 127.
- R4: After reset the fields hold the encoding of 550 µs: code 0, length 69.
- R5: A load strobe while not busy updates both fields together. The new values appear in the cycle after the strobe.
- R6: A load strobe while busy is ignored. Both fields keep their values.
- R7: A start in idle with length L and code n sets busy from the next cycle. Busy stays high until L·8·2^n tick strobes have been seen while busy. The cycle after the last of those ticks has timeout high and busy low, for exactly one cycle.
- R8: A reply strobe while busy returns the timer to idle in the next cycle, with no timeout pulse. A tick in that same cycle does not count.
- R9: A start with length 0 gives a timeout pulse in the next cycle, and busy never rises.
- R10: While busy, a start does not restart the count. While idle, ticks and reply strobes change neither busy nor timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Load strobe for the timeout value |
| cfg_timeout_us_i | input | TMO_W (16) | Requested reply timeout in microseconds |
| tick_1us_i | input | 1 | One-cycle strobe every microsecond |
| start_i | input | 1 | Request transmission finished; arm the timer |
| reply_i | input | 1 | Reply detected on the channel |
| cfg_len_o | output | 7 | Programmed length field |
| cfg_mul_o | output | 2 | Programmed granularity code |
| busy_o | output | 1 | Timer counting |
| timeout_o | output | 1 | One-cycle pulse when the period expires |

## Verification
A wrong unit counter or length counter shows as a timeout pulse that arrives some ticks early or late. The error is a whole unit, or a single tick, off the computed product. It is visible at the port within one period of the start. A wrong state or transition shows within a cycle of the triggering strobe:

- a busy flag that stays high after a reply;
- a pulse that lasts two cycles;
- a pulse that fires after a reply.

A wrong encoding boundary or rounding shows on the configuration outputs one cycle after a load. The bench therefore sweeps every timeout from 0 to 8200 µs, plus the extremes.

// File: rtl/aux_tmr_pkg.sv
package aux_tmr_pkg;

    localparam int unsigned LEN_W       = 7;
    localparam int unsigned MUL_W       = 2;
    localparam int unsigned LEN_MAX     = (1 << LEN_W) - 1;
    localparam int unsigned STEP_US     = 1016;
    localparam int unsigned UNIT_SHIFT0 = 3;
    localparam int unsigned SUB_W       = UNIT_SHIFT0 + (1 << MUL_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic [MUL_W-1:0] mul;
        logic [LEN_W-1:0] len;
    } tmo_cfg_t;

    // Range pick, ceiling division by the unit, clamp to the field maximum.
    function automatic tmo_cfg_t tmo_encode(input logic [31:0] us);
        tmo_cfg_t    r;
        logic [31:0] sh;
        logic [31:0] q;
        logic [31:0] rem_mask;
        if (us <= 32'(STEP_US))
            r.mul = 2'd0;
        else if (us <= 32'(2 * STEP_US))
            r.mul = 2'd1;
        else if (us <= 32'(4 * STEP_US))
            r.mul = 2'd2;
        else
            r.mul = 2'd3;
        sh       = 32'(UNIT_SHIFT0) + 32'(r.mul);
        rem_mask = (32'd1 << sh) - 32'd1;
        q        = (us >> sh) + (((us & rem_mask) != 32'd0) ? 32'd1 : 32'd0);
        r.len    = (q > 32'(LEN_MAX)) ? LEN_W'(LEN_MAX) : q[LEN_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/aux_tmo_encoder.sv
module aux_tmo_encoder
    import aux_tmr_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic [TMO_W-1:0] timeout_us_i,
    output tmo_cfg_t         cfg_o
);

    logic [31:0] us_ext;

    generate
        if (TMO_W < 32) begin : g_pad
            assign us_ext = {{(32 - TMO_W){1'b0}}, timeout_us_i};
        end else begin : g_trunc
            assign us_ext = timeout_us_i[31:0];
        end
    endgenerate

    always_comb begin
        cfg_o = tmo_encode(us_ext);
    end

endmodule

// File: rtl/aux_tmo_cfg.sv
module aux_tmo_cfg
    import aux_tmr_pkg::*;
#(
    parameter int unsigned DEFAULT_US = 550
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  logic     busy_i,
    input  tmo_cfg_t enc_i,
    output tmo_cfg_t cfg_o
);

    localparam tmo_cfg_t CFG_RST = tmo_encode(32'(DEFAULT_US));

    tmo_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (load_i && !busy_i) begin
            cfg_q <= enc_i;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/aux_tmo_fsm.sv
module aux_tmo_fsm
    import aux_tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  tmo_cfg_t cfg_i,
    input  logic     tick_i,
    input  logic     start_i,
    input  logic     reply_i,
    output logic     busy_o,
    output logic     timeout_o
);

    tmr_state_e       state_q;
    tmr_state_e       state_d;
    logic [LEN_W-1:0] rem_q;
    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] unit_last;
    logic             unit_done;
    logic             period_done;

    // Last sub-count of a unit, one entry per granularity code.
    always_comb begin
        unit_last = '0;
        for (int i = 0; i < (1 << MUL_W); i++) begin
            if (cfg_i.mul == MUL_W'(i))
                unit_last = SUB_W'((1 << (UNIT_SHIFT0 + i)) - 1);
        end
    end

    assign unit_done   = tick_i && (sub_q == unit_last);
    assign period_done = unit_done && (rem_q == LEN_W'(1));

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i)
                    state_d = (cfg_i.len == '0) ? ST_FIRE : ST_RUN;
            end
            ST_RUN: begin
                if (reply_i)
                    state_d = ST_IDLE;
                else if (period_done)
                    state_d = ST_FIRE;
            end
            ST_FIRE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Unit and length counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            sub_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            rem_q <= cfg_i.len;
            sub_q <= '0;
        end else if (state_q == ST_RUN && tick_i && !reply_i) begin
            if (unit_done) begin
                sub_q <= '0;
                rem_q <= rem_q - LEN_W'(1);
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end
    end

    // Outputs from state.
    always_comb begin
        busy_o    = 1'b0;
        timeout_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  busy_o    = 1'b1;
            ST_FIRE: timeout_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/aux_reply_timer.sv
module aux_reply_timer
    import aux_tmr_pkg::*;
#(
    parameter int unsigned TMO_W      = 16,
    parameter int unsigned DEFAULT_US = 550
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load_i,
    input  logic [TMO_W-1:0] cfg_timeout_us_i,
    input  logic             tick_1us_i,
    input  logic             start_i,
    input  logic             reply_i,
    output logic [LEN_W-1:0] cfg_len_o,
    output logic [MUL_W-1:0] cfg_mul_o,
    output logic             busy_o,
    output logic             timeout_o
);

    tmo_cfg_t enc;
    tmo_cfg_t cfg;
    logic     busy;

    aux_tmo_encoder #(.TMO_W(TMO_W)) u_enc (
        .timeout_us_i (cfg_timeout_us_i),
        .cfg_o        (enc)
    );

    aux_tmo_cfg #(.DEFAULT_US(DEFAULT_US)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cfg_load_i),
        .busy_i (busy),
        .enc_i  (enc),
        .cfg_o  (cfg)
    );

    aux_tmo_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg),
        .tick_i    (tick_1us_i),
        .start_i   (start_i),
        .reply_i   (reply_i),
        .busy_o    (busy),
        .timeout_o (timeout_o)
    );

    assign busy_o    = busy;
    assign cfg_len_o = cfg.len;
    assign cfg_mul_o = cfg.mul;

endmodule

// File: rtl/aux_reply_timer_chk.sv
module aux_reply_timer_chk
    import aux_tmr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load_i,
    input logic             start_i,
    input logic             reply_i,
    input logic [LEN_W-1:0] cfg_len_o,
    input logic [MUL_W-1:0] cfg_mul_o,
    input logic             busy_o,
    input logic             timeout_o
);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    a_r7_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && timeout_o));

    a_r6_load_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cfg_load_i) |=> ($stable(cfg_len_o) && $stable(cfg_mul_o)));

    a_r8_reply_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && reply_i) |=> (!busy_o && !timeout_o));

    a_r9_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !timeout_o && start_i && cfg_len_o == '0) |=> (timeout_o && !busy_o));

    a_r7_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !timeout_o && start_i && cfg_len_o != '0) |=> busy_o);

    a_r10_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !timeout_o && !start_i) |=> !busy_o);

endmodule

bind aux_reply_timer aux_reply_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load_i (cfg_load_i),
    .start_i    (start_i),
    .reply_i    (reply_i),
    .cfg_len_o  (cfg_len_o),
    .cfg_mul_o  (cfg_mul_o),
    .busy_o     (busy_o),
    .timeout_o  (timeout_o)
);

// File: tb/aux_reply_timer_bench.sv
module aux_reply_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load_i = 1'b0;
    logic [15:0] cfg_timeout_us_i = '0;
    logic        tick_1us_i = 1'b0;
    logic        start_i = 1'b0;
    logic        reply_i = 1'b0;
    logic [6:0]  cfg_len_o;
    logic [1:0]  cfg_mul_o;
    logic        busy_o;
    logic        timeout_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    aux_reply_timer u_aux_reply_timer (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_load_i       (cfg_load_i),
        .cfg_timeout_us_i (cfg_timeout_us_i),
        .tick_1us_i       (tick_1us_i),
        .start_i          (start_i),
        .reply_i          (reply_i),
        .cfg_len_o        (cfg_len_o),
        .cfg_mul_o        (cfg_mul_o),
        .busy_o           (busy_o),
        .timeout_o        (timeout_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mul(input int t);
        if (t <= 1016) return 0;
        if (t <= 2032) return 1;
        if (t <= 4064) return 2;
        return 3;
    endfunction

    function automatic int exp_len(input int t);
        int u;
        int q;
        u = 8 * (1 << exp_mul(t));
        q = t / u + ((t % u) != 0 ? 1 : 0);
        return (q > 127) ? 127 : q;
    endfunction

    task automatic load(input int t);
        cfg_timeout_us_i = 16'(t);
        cfg_load_i = 1'b1;
        @(negedge clk);
        cfg_load_i = 1'b0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic one_tick();
        tick_1us_i = 1'b1;
        @(negedge clk);
        tick_1us_i = 1'b0;
    endtask

    // Full run to expiry with ticks every other cycle.
    task automatic run_full(input int t);
        int n;
        load(t);
        n = exp_len(t) * 8 * (1 << exp_mul(t));
        pulse_start();
        if (n == 0) begin
            chk("R9 timeout", int'(timeout_o), 1);
            chk("R9 busy", int'(busy_o), 0);
        end else begin
            chk("R7 busy after start", int'(busy_o), 1);
            for (int k = 1; k <= n; k++) begin
                one_tick();
                if (k < n) begin
                    if (busy_o !== 1'b1 || timeout_o !== 1'b0)
                        chk("R7 early expiry", int'(timeout_o) * 2 + int'(busy_o), 1);
                    @(negedge clk);
                end
            end
            chk("R7 timeout at period", int'(timeout_o), 1);
            chk("R7 busy clear at period", int'(busy_o), 0);
        end
        @(negedge clk);
        chk("R7 pulse one cycle", int'(timeout_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset mul", int'(cfg_mul_o), 0);
        chk("R4 reset len", int'(cfg_len_o), 69);
        chk("R4 reset busy", int'(busy_o), 0);
        chk("R4 reset timeout", int'(timeout_o), 0);

        // R1 R2 R3 R5 exhaustive encoding sweep
        for (int t = 0; t <= 8200; t++) begin
            load(t);
            if (int'(cfg_mul_o) != exp_mul(t)) chk("R1 mul", int'(cfg_mul_o), exp_mul(t));
            else checks = checks + 1;
            if (int'(cfg_len_o) != exp_len(t)) chk("R2 R5 len", int'(cfg_len_o), exp_len(t));
            else checks = checks + 1;
        end
        load(65535);
        chk("R3 clamp len", int'(cfg_len_o), 127);
        chk("R1 max mul", int'(cfg_mul_o), 3);
        load(1016);
        chk("R1 edge 1016 mul", int'(cfg_mul_o), 0);
        chk("R2 edge 1016 len", int'(cfg_len_o), 127);
        load(1017);
        chk("R1 edge 1017 mul", int'(cfg_mul_o), 1);
        chk("R2 edge 1017 len", int'(cfg_len_o), 64);

        // R7 R9 timing runs
        run_full(0);
        run_full(1);
        run_full(8);
        run_full(23);
        run_full(550);
        run_full(1017);
        run_full(2100);
        run_full(10000);

        // R8 reply stops the timer, tick in same cycle ignored
        load(100);
        pulse_start();
        repeat (5) one_tick();
        reply_i = 1'b1;
        tick_1us_i = 1'b1;
        @(negedge clk);
        reply_i = 1'b0;
        tick_1us_i = 1'b0;
        chk("R8 busy after reply", int'(busy_o), 0);
        chk("R8 no timeout after reply", int'(timeout_o), 0);
        for (int k = 0; k < 120; k++) one_tick();
        chk("R10 idle ticks no timeout", int'(timeout_o), 0);
        chk("R10 idle ticks no busy", int'(busy_o), 0);

        // R6 load while busy ignored
        load(100);
        pulse_start();
        load(3000);
        chk("R6 len kept", int'(cfg_len_o), 13);
        chk("R6 mul kept", int'(cfg_mul_o), 0);
        reply_i = 1'b1;
        @(negedge clk);
        reply_i = 1'b0;
        load(3000);
        chk("R5 len after idle load", int'(cfg_len_o), 94);
        chk("R5 mul after idle load", int'(cfg_mul_o), 2);

        // R10 start while busy does not restart the count
        load(8);
        pulse_start();
        repeat (4) one_tick();
        pulse_start();
        chk("R10 still busy", int'(busy_o), 1);
        repeat (3) one_tick();
        chk("R10 no early timeout", int'(timeout_o), 0);
        one_tick();
        chk("R10 timeout at original period", int'(timeout_o), 1);
        @(negedge clk);

        // R10 reply while idle has no effect
        reply_i = 1'b1;
        @(negedge clk);
        reply_i = 1'b0;
        chk("R10 idle reply busy", int'(busy_o), 0);
        chk("R10 idle reply timeout", int'(timeout_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule